// File: doc/BRIEF.md
# Error-Dropping Multiply-Accumulate Column

This block is one column of a weight-stationary systolic multiply-accumulate array. It is built to run past its timing margin. Each cell holds a signed 8-bit weight that is loaded before a block of work and then held. Each cell multiplies that weight by a signed 8-bit activation and adds the product to a 24-bit partial sum, which it registers and passes to the next cell. Activations arrive as one vector per item and are skewed inside the block, so that lane k reaches cell k exactly k cycles after lane 0 reaches cell 0. The column accepts one item per clock and returns one sum per clock. It never stalls.

Timing faults are modelled at RTL. Each cell has a few protected high-order bits in its sum register, and an injection field can flip them. The cell's error flag is the OR of its injection bits. Beside the corruptible main register, each cell keeps a shadow copy of its true sum. When a cell is flagged, its successor spends its cycle forwarding that shadow value through a 2:1 mux, so the successor's own product is lost. The erring cell's sum is therefore repaired and no cycle is spent. A final mux repairs an error in the last cell in the same way. The injection fields travel through the skew together with their item's activations.

Top module: `drop_mac_column`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` is 0 and `out_sum` is 0.
- R2: `wt_vec` is copied into the cell weights on a rising edge where `wt_load` is 1. At all other times, changes on `wt_vec` have no effect on later results. Cell k's weight is `wt_vec[k*8 +: 8]`, signed.
- R3: An item sampled with `in_valid` high on rising edge e appears with `out_valid` high after edge e+N_CELLS-1. Cell k's activation is `act_vec[k*8 +: 8]`, signed.
- R4: Items sampled on consecutive edges give results on consecutive cycles, in the same order, with no stall or gap. No `out_valid` occurs without a matching input.
- R5: With no injection, `out_sum` is the two's-complement sum over all cells of weight times activation, truncated to 24 bits.
- R6: Cell k's error flag is the OR of `inj_vec[k*PROT_W +: PROT_W]`. A flagged cell's main register has its top PROT_W sum bits flipped by that field, while its shadow register holds the true sum.
- R7: The cell after a flagged cell forwards the flagged cell's shadow sum unchanged and adds no product of its own. The result is the full sum minus every term whose preceding cell was flagged.
- R8: A cell that is forwarding its predecessor's shadow sum ignores its own injection field in that cycle and raises no flag.
- R9: When the last cell is flagged, `out_sum` still carries that cell's true sum.
- R10: Injection fields and activations presented with `in_valid` low produce no output and do not disturb neighbouring items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_load | input | 1 | Capture `wt_vec` into the cell weights |
| wt_vec | input | N_CELLS*8 | Packed signed weights, cell 0 in the low byte |
| in_valid | input | 1 | An item is present on `act_vec` / `inj_vec` |
| act_vec | input | N_CELLS*8 | Packed signed activations, cell 0 in the low byte |
| inj_vec | input | N_CELLS*PROT_W | Per-cell error injection fields, cell 0 lowest |
| out_valid | output | 1 | `out_sum` holds a finished result |
| out_sum | output | 24 | Corrected accumulated sum |

## Verification
The properties assume that weights are reloaded only when no item is in flight, because a reload mid-stream would change the weight seen by items already partly through the column. The bench therefore waits for the column to drain before every `wt_load`. The properties also assume that an injection field is only meaningful when it arrives with a valid item. The stimulus drives nonzero fields during bubbles on purpose, to show that those fields are discarded. Error patterns sweep all 256 flag combinations for the eight cells, and the bench predicts each result from the drop rule alone.

// File: rtl/dmc_pkg.sv
// Package: shared width constants for the error-dropping MAC column.
// Assumes: operands are signed two's complement; sums wrap at ACC_W bits.
package dmc_pkg;
    localparam int OP_W  = 8;
    localparam int ACC_W = 24;
endpackage

// File: rtl/dmc_skew.sv
// Module: dmc_skew
// Delays lane k of a packed input by k clock cycles (lane 0 passes straight
// through), giving the diagonal wavefront a systolic column needs.
// Assumes: all lanes share one width; reset clears every delay stage.
module dmc_skew #(
    parameter int LANES  = 8,
    parameter int LANE_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] lanes_in,
    output logic [LANES*LANE_W-1:0] lanes_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_direct
            assign lanes_out[0 +: LANE_W] = lanes_in[0 +: LANE_W];
        end else begin : g_delay
            logic [LANE_W-1:0] stage [k];
            // shift the lane one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < k; s++) stage[s] <= '0;
                end else begin
                    stage[0] <= lanes_in[k*LANE_W +: LANE_W];
                    for (int s = 1; s < k; s++) stage[s] <= stage[s-1];
                end
            end
            assign lanes_out[k*LANE_W +: LANE_W] = stage[k-1];
        end
    end
endmodule

// File: rtl/dmc_cell.sv
// Module: dmc_cell
// One multiply-accumulate stage. It keeps a main (corruptible) and a shadow
// (true) sum register. If the previous stage is flagged, it forwards that
// stage's shadow sum, drops its own product and ignores its own injection.
// Assumes: injection only acts on valid slots; weight is stable while busy.
module dmc_cell #(
    parameter int OP_W   = 8,
    parameter int ACC_W  = 24,
    parameter int PROT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   wt_i,
    input  logic [OP_W-1:0]   act_i,
    input  logic              vld_i,
    input  logic [PROT_W-1:0] inj_i,
    input  logic [ACC_W-1:0]  prev_main_i,
    input  logic [ACC_W-1:0]  prev_shdw_i,
    input  logic              prev_flag_i,
    output logic [ACC_W-1:0]  main_o,
    output logic [ACC_W-1:0]  shdw_o,
    output logic              flag_o,
    output logic              vld_o
);
    localparam int PROD_W = 2 * OP_W;

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_x;
    logic [ACC_W-1:0]         true_sum;
    logic [PROT_W-1:0]        eff_inj;
    logic [ACC_W-1:0]         fault_mask;

    // signed product, sign-extended to the accumulator width
    always_comb begin
        prod   = $signed(wt_i) * $signed(act_i);
        prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    // 2:1 recovery mux: forward the predecessor's shadow sum, or accumulate
    always_comb begin
        true_sum = prev_flag_i ? prev_shdw_i : (prev_main_i + prod_x);
    end

    // fault model: injection only counts on a valid, non-bypassed slot
    always_comb begin
        eff_inj    = (prev_flag_i || !vld_i) ? '0 : inj_i;
        fault_mask = {eff_inj, {(ACC_W-PROT_W){1'b0}}};
    end

    // main/shadow sum registers, flag and valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_o <= '0;
            shdw_o <= '0;
            flag_o <= 1'b0;
            vld_o  <= 1'b0;
        end else begin
            main_o <= true_sum ^ fault_mask;
            shdw_o <= true_sum;
            flag_o <= |eff_inj;
            vld_o  <= vld_i;
        end
    end
endmodule

// File: rtl/drop_mac_column.sv
// Module: drop_mac_column (top)
// A weight-stationary column of N_CELLS MAC stages. It recovers from a
// flagged stage by dropping the next stage's term instead of stalling.
// Assumes: wt_load is raised only while no item is in flight.
module drop_mac_column
    import dmc_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int PROT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wt_load,
    input  logic [N_CELLS*OP_W-1:0]   wt_vec,
    input  logic                      in_valid,
    input  logic [N_CELLS*OP_W-1:0]   act_vec,
    input  logic [N_CELLS*PROT_W-1:0] inj_vec,
    output logic                      out_valid,
    output logic [ACC_W-1:0]          out_sum
);
    localparam int LANE_W = 1 + OP_W + PROT_W;
    localparam int LAST   = N_CELLS - 1;

    logic [N_CELLS*OP_W-1:0]   wt_q;
    logic [N_CELLS*LANE_W-1:0] lane_in;
    logic [N_CELLS*LANE_W-1:0] lane_sk;
    logic [N_CELLS*ACC_W-1:0]  c_main;
    logic [N_CELLS*ACC_W-1:0]  c_shdw;
    logic [N_CELLS-1:0]        c_flag;
    logic [N_CELLS-1:0]        c_vld;

    // stationary weight store, written only on wt_load
    always_ff @(posedge clk) begin
        if (!rst_n)       wt_q <= '0;
        else if (wt_load) wt_q <= wt_vec;
    end

    // pack each lane as {valid, activation, injection}
    for (genvar k = 0; k < N_CELLS; k++) begin : g_pack
        assign lane_in[k*LANE_W +: LANE_W] =
            {in_valid, act_vec[k*OP_W +: OP_W], inj_vec[k*PROT_W +: PROT_W]};
    end

    dmc_skew #(.LANES(N_CELLS), .LANE_W(LANE_W)) u_skew (
        .clk       (clk),
        .rst_n     (rst_n),
        .lanes_in  (lane_in),
        .lanes_out (lane_sk)
    );

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        logic [ACC_W-1:0] pm;
        logic [ACC_W-1:0] ps;
        logic             pf;
        if (k == 0) begin : g_head
            assign pm = '0;
            assign ps = '0;
            assign pf = 1'b0;
        end else begin : g_link
            assign pm = c_main[(k-1)*ACC_W +: ACC_W];
            assign ps = c_shdw[(k-1)*ACC_W +: ACC_W];
            assign pf = c_flag[k-1];
        end
        dmc_cell #(.OP_W(OP_W), .ACC_W(ACC_W), .PROT_W(PROT_W)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .wt_i        (wt_q[k*OP_W +: OP_W]),
            .act_i       (lane_sk[k*LANE_W + PROT_W +: OP_W]),
            .vld_i       (lane_sk[k*LANE_W + PROT_W + OP_W]),
            .inj_i       (lane_sk[k*LANE_W +: PROT_W]),
            .prev_main_i (pm),
            .prev_shdw_i (ps),
            .prev_flag_i (pf),
            .main_o      (c_main[k*ACC_W +: ACC_W]),
            .shdw_o      (c_shdw[k*ACC_W +: ACC_W]),
            .flag_o      (c_flag[k]),
            .vld_o       (c_vld[k])
        );
    end

    // tail recovery mux: repair an error flagged in the last stage
    always_comb begin
        out_valid = c_vld[LAST];
        out_sum   = c_flag[LAST] ? c_shdw[LAST*ACC_W +: ACC_W]
                                 : c_main[LAST*ACC_W +: ACC_W];
    end
endmodule

// File: rtl/dmc_chk.sv
// Module: dmc_chk
// Property checker for drop_mac_column; bound into every instance below.
// Assumes: weights are reloaded only while the column is idle.
module dmc_chk #(
    parameter int N_CELLS = 8,
    parameter int PROT_W  = 4,
    parameter int OP_W    = 8,
    parameter int ACC_W   = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wt_load,
    input logic [N_CELLS*OP_W-1:0]  wt_q,
    input logic [N_CELLS*ACC_W-1:0] c_main,
    input logic [N_CELLS*ACC_W-1:0] c_shdw,
    input logic [N_CELLS-1:0]       c_flag,
    input logic [N_CELLS-1:0]       c_vld,
    input logic                     out_valid,
    input logic [ACC_W-1:0]         out_sum
);
    localparam int LAST = N_CELLS - 1;

    a_r2_weight_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wt_load |=> $stable(wt_q));

    a_r9_out_corrected: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == c_shdw[LAST*ACC_W +: ACC_W]);

    for (genvar k = 0; k < N_CELLS; k++) begin : g_stage
        a_r6_flag_corrupts: assert property (@(posedge clk) disable iff (!rst_n)
            c_flag[k] |-> c_main[k*ACC_W +: ACC_W] != c_shdw[k*ACC_W +: ACC_W]);
        a_r6_clean_match: assert property (@(posedge clk) disable iff (!rst_n)
            !c_flag[k] |-> c_main[k*ACC_W +: ACC_W] == c_shdw[k*ACC_W +: ACC_W]);
        a_r10_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            !c_vld[k] |-> !c_flag[k]);
        if (k > 0) begin : g_link
            a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
                c_flag[k-1] |=> c_shdw[k*ACC_W +: ACC_W] == $past(c_shdw[(k-1)*ACC_W +: ACC_W]));
            a_r8_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                c_flag[k-1] |=> !c_flag[k]);
            a_r4_valid_chain: assert property (@(posedge clk) disable iff (!rst_n)
                c_vld[k-1] |=> c_vld[k]);
        end
    end
endmodule

bind drop_mac_column dmc_chk #(
    .N_CELLS (N_CELLS),
    .PROT_W  (PROT_W),
    .OP_W    (dmc_pkg::OP_W),
    .ACC_W   (dmc_pkg::ACC_W)
) u_dmc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_load   (wt_load),
    .wt_q      (wt_q),
    .c_main    (c_main),
    .c_shdw    (c_shdw),
    .c_flag    (c_flag),
    .c_vld     (c_vld),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/drop_mac_column_bench.sv
// Bench for drop_mac_column: 8 cells, 4 protected bits. It sweeps all error
// flag patterns and predicts each sum from the drop rule.
module drop_mac_column_bench;
    localparam int N  = 8;
    localparam int PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wt_load = 1'b0;
    logic [N*8-1:0]    wt_vec = '0;
    logic              in_valid = 1'b0;
    logic [N*8-1:0]    act_vec = '0;
    logic [N*PW-1:0]   inj_vec = '0;
    logic              out_valid;
    logic [23:0]       out_sum;

    int errors = 0;
    int checks = 0;
    int nidx = 0;
    bit done = 1'b0;
    int wm [N];
    logic [23:0] q_sum [$];
    int          q_due [$];
    string       q_tag [$];

    always #2 clk = ~clk;

    drop_mac_column #(.N_CELLS(N), .PROT_W(PW)) u_drop_mac_column (
        .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_vec(wt_vec),
        .in_valid(in_valid), .act_vec(act_vec), .inj_vec(inj_vec),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // prediction: a term is lost when the previous effective flag was set
    function automatic logic [23:0] predict(input logic [N*8-1:0] av, input logic [N*PW-1:0] iv);
        int s = 0;
        bit ep = 1'b0;
        for (int k = 0; k < N; k++) begin
            bit en;
            if (!ep) s += wm[k] * int'($signed(av[k*8 +: 8]));
            en = (iv[k*PW +: PW] != 0) && !ep;
            ep = en;
        end
        return s[23:0];
    endfunction

    // output side, sampled at the falling edge
    task automatic observe();
        if (q_due.size() != 0 && q_due[0] == nidx) begin
            check(out_valid === 1'b1, "R3 latency", int'(out_valid), 1);
            check(out_sum === q_sum[0], q_tag[0], int'($signed(out_sum)), int'($signed(q_sum[0])));
            void'(q_sum.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
        end else if (out_valid === 1'b1) begin
            check(1'b0, "R4/R10 spurious out_valid", 1, 0);
        end
    endtask

    task automatic tick(input bit v, input logic [N*8-1:0] av, input logic [N*PW-1:0] iv,
                        input bit wl, input logic [N*8-1:0] wv, input string tag);
        @(negedge clk);
        nidx++;
        observe();
        in_valid = v; act_vec = av; inj_vec = iv; wt_load = wl; wt_vec = wv;
        if (wl) for (int k = 0; k < N; k++) wm[k] = int'($signed(wv[k*8 +: 8]));
        if (v) begin
            q_sum.push_back(predict(av, iv));
            q_due.push_back(nidx + N);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        for (int c = 0; c < N + 3; c++) tick(1'b0, '0, '1, 1'b0, wt_vec, "");
    endtask

    function automatic logic [N*8-1:0] rnd_vec();
        logic [N*8-1:0] r;
        for (int k = 0; k < N; k++) r[k*8 +: 8] = 8'($urandom);
        return r;
    endfunction

    function automatic logic [N*PW-1:0] flags_to_inj(input int p);
        logic [N*PW-1:0] r = '0;
        for (int k = 0; k < N; k++)
            if (p[k]) r[k*PW +: PW] = PW'(((p * 7 + k) % 15) + 1);
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N*8-1:0] w1;
        for (int k = 0; k < N; k++) wm[k] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_sum === 24'd0, "R1 out_sum in reset", int'(out_sum), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_sum === 24'd0, "R1 after release", int'(out_sum), 0);

        // load a mixed weight set
        w1 = rnd_vec();
        tick(1'b0, '0, '0, 1'b1, w1, "");
        // R5 error-free stream, back to back (R4)
        for (int i = 0; i < 20; i++) tick(1'b1, rnd_vec(), '0, 1'b0, w1, "R5 clean sum");
        // R7 exhaustive sweep of flag patterns, back to back
        for (int p = 0; p < 256; p++)
            tick(1'b1, rnd_vec(), flags_to_inj(p), 1'b0, w1, "R7 drop pattern");
        // R10: bubbles with nonzero injection between items
        for (int i = 0; i < 10; i++) begin
            tick(1'b0, rnd_vec(), '1, 1'b0, w1, "");
            tick(1'b1, rnd_vec(), '0, 1'b0, w1, "R10 item after bubble");
        end
        // R2: wt_vec toggles with wt_load low, model weights unchanged
        for (int i = 0; i < 12; i++) tick(1'b1, rnd_vec(), flags_to_inj(i * 37), 1'b0, rnd_vec(), "R2 weight hold");
        drain();

        // extremes: all weights -128
        tick(1'b0, '0, '0, 1'b1, {N{8'h80}}, "");
        tick(1'b1, {N{8'h80}}, '0, 1'b0, {N{8'h80}}, "R5 max positive");
        tick(1'b1, {N{8'h7f}}, '0, 1'b0, {N{8'h80}}, "R5 max negative");
        // R9: only the last cell flagged, every injection value
        for (int v = 1; v < 16; v++)
            tick(1'b1, rnd_vec(), {PW'(v), {(N-1)*PW{1'b0}}}, 1'b0, {N{8'h80}}, "R9 last cell flagged");
        // R8: every cell injected; bypassed ones must ignore theirs
        for (int i = 0; i < 8; i++)
            tick(1'b1, rnd_vec(), {N{PW'(i + 1)}}, 1'b0, {N{8'h80}}, "R8 all injected");
        // R6: a lone flag on cell 0 with each field value
        for (int v = 1; v < 16; v++)
            tick(1'b1, {N{8'h7f}}, {{(N-1)*PW{1'b0}}, PW'(v)}, 1'b0, {N{8'h80}}, "R6 flag from field OR");
        drain();
        check(q_due.size() == 0, "R4 all results returned", q_due.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule